// File: doc/BRIEF.md
# Processor-Local Countdown Timer

This block is a countdown timer that sits beside a processor core and interrupts it after a programmed interval. Software gives it three values: an initial count, a divide setting and a timer entry made of a mode field, a mask bit and an 8-bit vector. The counter steps down once every N bus clocks, where N is the ratio chosen by the divide setting. When the count runs out, the timer emits a request that carries the vector, unless the entry is masked. In one-shot mode the count then stays at zero. In periodic mode it reloads from the initial count.

The register-bus decode lives elsewhere. The block gets one write strobe per register, with the data beside it, and returns the current count as a plain output. Deadline mode is decoded only so that the count reads as zero while it is selected. In that mode the countdown does not advance.

Top module: `local_tmr`

## Requirements
- R1: The divide ratio is 2 to the power S, where S is the 3-bit sum `{cfg[3], cfg[1:0]} + 1` with the carry dropped. So `{cfg[3],cfg[1:0]} = 3'b111` gives divide-by-1 and all zeros gives divide-by-2. Bit 2 of the setting is ignored.
- R2: After an initial-count write of C ≠ 0 at edge E0, in a counting mode, the count read after edge E0+k is C − floor(k/N). The count expires at edge E0 + C·N.
- R3: An initial count of zero does not start the timer. The count reads zero and no request is raised.
- R4: Writing the initial count restarts the countdown from the new value and restarts the divide phase, even while a countdown is in progress.
- R5: In one-shot mode (mode 2'b00, and 2'b11 behaves the same) the count stays at zero after expiry and no further request follows.
- R6: In periodic mode (mode 2'b01) the count reloads from the initial count on expiry. A request follows every C·N bus clocks, and the count reads C − floor((k mod C·N)/N).
- R7: In deadline mode (mode 2'b10) the count reads zero and no request is raised.
- R8: When the mask bit is 1, no request is raised, and the count still advances and expires as usual.
- R9: Each expiry raises `irq_valid` for exactly one cycle, in the cycle that follows the expiry edge, and `irq_vector` then holds the programmed vector.
- R10: After reset the count reads zero and no request is pending. The entry is masked, in one-shot mode, and the divide setting is zero (divide-by-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| icnt_we | input | 1 | Initial-count write strobe |
| icnt_wdata | input | CNT_W | Initial count |
| divcfg_we | input | 1 | Divide-setting write strobe |
| divcfg_wdata | input | 4 | Divide setting |
| lvt_we | input | 1 | Timer-entry write strobe |
| lvt_mode | input | 2 | Mode: 00 one-shot, 01 periodic, 10 deadline, 11 one-shot |
| lvt_mask | input | 1 | 1 masks the request |
| lvt_vector | input | VEC_W | Vector carried by the request |
| cur_count | output | CNT_W | Current count |
| irq_valid | output | 1 | One-cycle request pulse |
| irq_vector | output | VEC_W | Vector of the request |

## Verification
A sweep walks all sixteen divide settings with a short count. This separates the non-contiguous bit decode, the ignored bit 2 and the wrap of the all-ones code to divide-by-1. Random trials mix counts, divide settings, modes, masks and vectors. A per-cycle count check set against the request timing tells a one-shot that halts apart from a periodic reload, and shows that a mask blocks only the request. Directed cases cover a restart in the middle of a count, a write of zero that stops a running periodic timer, deadline mode, and the reset defaults.

// File: rtl/loctmr_pkg.sv
package loctmr_pkg;

  typedef enum logic [1:0] {
    TM_ONESHOT  = 2'b00,
    TM_PERIODIC = 2'b01,
    TM_DEADLINE = 2'b10,
    TM_RSVD     = 2'b11
  } tmr_mode_e;

  localparam int SHIFT_W = 3;

  // Divide exponent: the three scattered bits, plus one, kept to three bits.
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] base;
    base = {cfg[3], cfg[1:0]};
    return base + 3'd1;
  endfunction

  // Deadline mode never advances the countdown.
  function automatic logic mode_counts(input tmr_mode_e m);
    return m != TM_DEADLINE;
  endfunction

  function automatic logic mode_reloads(input tmr_mode_e m);
    return m == TM_PERIODIC;
  endfunction

endpackage

// File: rtl/loctmr_prescaler.sv
module loctmr_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               enable,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W:0]   ratio_full;
  logic [PRE_W-1:0] ratio_m1;
  logic [PRE_W-1:0] pre_q;

  assign ratio_full = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
  assign ratio_m1   = ratio_full[PRE_W-1:0];
  assign tick       = enable && !clear && (pre_q == ratio_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (clear)   pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else if (enable)  pre_q <= pre_q + 1'b1;
  end

  // R1: a ratio above one never yields two ticks in a row
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio_m1 != '0 && !clear) |=> !tick);

endmodule

// File: rtl/loctmr_countdown.sv
module loctmr_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick && !load && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (expire) cnt_q <= periodic ? reload_val : '0;
    else if (tick)   cnt_q <= cnt_q - ONE;
  end

  // R2: without a load the count moves down by at most one per clock
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - ONE));

  // R5: an exhausted count stays exhausted until reloaded by a write
  p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/local_tmr.sv
module local_tmr #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             icnt_we,
  input  logic [CNT_W-1:0] icnt_wdata,
  input  logic             divcfg_we,
  input  logic [3:0]       divcfg_wdata,
  input  logic             lvt_we,
  input  logic [1:0]       lvt_mode,
  input  logic             lvt_mask,
  input  logic [VEC_W-1:0] lvt_vector,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  import loctmr_pkg::*;

  logic [CNT_W-1:0]   icnt_q;
  logic [3:0]         divcfg_q;
  tmr_mode_e          mode_q;
  logic               mask_q;
  logic [VEC_W-1:0]   vec_q;
  logic               irq_q;
  logic [VEC_W-1:0]   irq_vec_q;

  logic [CNT_W-1:0]   cnt_q;
  logic               run;
  logic               tick;
  logic               expire;
  logic               pre_clear;
  logic [SHIFT_W-1:0] shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q   <= '0;
      divcfg_q <= '0;
      mode_q   <= TM_ONESHOT;
      mask_q   <= 1'b1;
      vec_q    <= '0;
    end else begin
      if (icnt_we)   icnt_q   <= icnt_wdata;
      if (divcfg_we) divcfg_q <= divcfg_wdata;
      if (lvt_we) begin
        mode_q <= tmr_mode_e'(lvt_mode);
        mask_q <= lvt_mask;
        vec_q  <= lvt_vector;
      end
    end
  end

  assign shift     = div_shift(divcfg_q);
  assign run       = mode_counts(mode_q) && (cnt_q != '0);
  assign pre_clear = icnt_we || divcfg_we;

  loctmr_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (pre_clear),
    .enable (run),
    .shift  (shift),
    .tick   (tick)
  );

  loctmr_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (icnt_we),
    .load_val   (icnt_wdata),
    .tick       (tick),
    .periodic   (mode_reloads(mode_q)),
    .reload_val (icnt_q),
    .cnt_q      (cnt_q),
    .expire     (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      irq_vec_q <= '0;
    end else begin
      irq_q <= expire && !mask_q;
      if (expire) irq_vec_q <= vec_q;
    end
  end

  assign cur_count  = (mode_q == TM_DEADLINE || icnt_q == '0) ? '0 : cnt_q;
  assign irq_valid  = irq_q;
  assign irq_vector = irq_vec_q;

  // R8: a request never follows a cycle in which the entry was masked
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !$past(mask_q));

  // R9: every request is caused by a countdown expiry one cycle earlier
  p_expire_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(expire));

  // R7: staying in deadline mode never produces a request
  p_deadline_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TM_DEADLINE && $past(mode_q == TM_DEADLINE)) |-> !irq_q);

endmodule

// File: tb/local_tmr_bench.sv
`timescale 1ns/1ps
module local_tmr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        icnt_we = 1'b0;
  logic [31:0] icnt_wdata = '0;
  logic        divcfg_we = 1'b0;
  logic [3:0]  divcfg_wdata = '0;
  logic        lvt_we = 1'b0;
  logic [1:0]  lvt_mode = '0;
  logic        lvt_mask = 1'b0;
  logic [7:0]  lvt_vector = '0;
  logic [31:0] cur_count;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  local_tmr u_local_tmr (
    .clk(clk), .rst_n(rst_n),
    .icnt_we(icnt_we), .icnt_wdata(icnt_wdata),
    .divcfg_we(divcfg_we), .divcfg_wdata(divcfg_wdata),
    .lvt_we(lvt_we), .lvt_mode(lvt_mode), .lvt_mask(lvt_mask), .lvt_vector(lvt_vector),
    .cur_count(cur_count), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  // Ratio from the divide setting: index 7 wraps to 1, otherwise 2 << index (R1)
  function automatic int exp_ratio(input logic [3:0] cfg);
    int idx;
    idx = {cfg[3], cfg[1:0]};
    return (idx == 7) ? 1 : (2 << idx);
  endfunction

  // Mode code 3 behaves as one-shot; 2 is deadline; 1 periodic
  function automatic longint exp_count(input int ic, input int r, input int md, input int k);
    longint p;
    if (md == 2 || ic == 0) return 0;
    p = longint'(ic) * r;
    if (md == 1) return ic - (k % p) / r;
    return (k >= p) ? 0 : ic - k / r;
  endfunction

  function automatic bit exp_irq(input int ic, input int r, input int md, input bit msk, input int k);
    int p;
    if (md == 2 || ic == 0 || msk || k == 0) return 1'b0;
    p = ic * r;
    if (md == 1) return (k % p) == 0;
    return k == p;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_icnt(input int v);
    @(negedge clk); icnt_we = 1'b1; icnt_wdata = v;
    @(negedge clk); icnt_we = 1'b0;
  endtask

  task automatic wr_div(input logic [3:0] v);
    @(negedge clk); divcfg_we = 1'b1; divcfg_wdata = v;
    @(negedge clk); divcfg_we = 1'b0;
  endtask

  task automatic wr_lvt(input int md, input bit msk, input logic [7:0] vec);
    @(negedge clk); lvt_we = 1'b1; lvt_mode = md[1:0]; lvt_mask = msk; lvt_vector = vec;
    @(negedge clk); lvt_we = 1'b0;
  endtask

  // Called at the negedge right after the initial-count write edge (k = 0)
  task automatic observe(input int ic, input int r, input int md, input bit msk,
                         input logic [7:0] vec, input int ncyc, input string req);
    for (int k = 0; k < ncyc; k++) begin
      longint ec;
      bit ei;
      ec = exp_count(ic, r, md, k);
      ei = exp_irq(ic, r, md, msk, k);
      check(cur_count == ec, req, "count", cur_count, ec);
      check(irq_valid == ei, req, "irq_valid", irq_valid, ei);
      if (ei) check(irq_vector == vec, req, "irq_vector", irq_vector, vec);
      @(negedge clk);
    end
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5A17_C0DE);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset defaults
    check(cur_count == 0, "R10", "reset count", cur_count, 0);
    check(irq_valid == 0, "R10", "reset irq", irq_valid, 0);
    // R10: default is masked, one-shot, divide-by-2
    wr_icnt(2);
    observe(2, 2, 0, 1'b1, 8'h00, 8, "R10");

    // R1: sweep every divide setting
    for (int c = 0; c < 16; c++) begin
      logic [7:0] v;
      int r;
      v = 8'h20 + 8'(c);
      r = exp_ratio(4'(c));
      wr_lvt(0, 1'b0, v);
      wr_div(4'(c));
      wr_icnt(2);
      observe(2, r, 0, 1'b0, v, 2 * r + 3, "R1");
    end

    // R4: restart in the middle of a count
    wr_div(4'b0000);
    wr_lvt(1, 1'b0, 8'h41);
    wr_icnt(10);
    repeat (7) @(negedge clk);
    wr_icnt(4);
    observe(4, 2, 1, 1'b0, 8'h41, 20, "R4");

    // R3: writing zero stops a running periodic timer
    wr_icnt(0);
    observe(0, 2, 1, 1'b0, 8'h41, 50, "R3");

    // R7: deadline mode reads zero and never requests
    wr_lvt(2, 1'b0, 8'h55);
    wr_icnt(5);
    observe(5, 2, 2, 1'b0, 8'h55, 40, "R7");

    // R8: masked one-shot still counts down to zero, no request
    wr_lvt(0, 1'b1, 8'h66);
    wr_div(4'b1011);
    wr_icnt(3);
    observe(3, 1, 0, 1'b1, 8'h66, 10, "R8");

    // R5: one-shot stops at zero, single request
    wr_lvt(3, 1'b0, 8'h77);
    wr_icnt(3);
    observe(3, 1, 3, 1'b0, 8'h77, 12, "R5");

    // R2, R6, R9: random trials
    for (int t = 0; t < 24; t++) begin
      int ic, md, r;
      bit msk;
      logic [3:0] cfg;
      logic [7:0] vec;
      ic  = 1 + int'($urandom % 12);
      md  = int'($urandom % 4);
      cfg = 4'($urandom);
      msk = (($urandom % 4) == 0);
      vec = 8'($urandom);
      r   = exp_ratio(cfg);
      wr_lvt(md, msk, vec);
      wr_div(cfg);
      wr_icnt(ic);
      observe(ic, r, md, msk, vec, 2 * ic * r + 3, (md == 1) ? "R6" : "R2/R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule